// File: doc/BRIEF.md
# Channel Diagnostic Fault Register

This block keeps a two-bit health code for each output channel of a multi-channel low-side driver. For every channel it receives three raw fault levels: overload (which also covers a short to supply and overtemperature), short to ground, and open load. These levels are already digital. A raw condition counts only after it has stayed the same for a programmable number of clock cycles. When it qualifies, its code is written into that channel's slot. The code replaces whatever the slot held before.

A serial interface reads the register inside a chip-select frame. On the cycle where chip select is first seen low, the block captures a snapshot of all slots. The snapshot is a full-diagnosis byte plus a one-bit-per-channel summary, and it does not change while the frame shifts out. When chip select returns high, every slot goes back to the healthy code. A general fault flag is produced as a low-only drive enable, intended for an open-drain pin. It is asserted whenever any slot holds a fault.

Top module: `fault_diag_reg`

## Requirements
- R1: The channel code is 2'b11 for healthy, 2'b10 for overload, 2'b01 for open load and 2'b00 for short to ground.
- R2: Channel index i (0-based) sits at bits [2i+1:2i] of the diagnostic byte, so the highest channel holds the top two bits.
- R3: When several raw levels of one channel are high together, overload is chosen first, then short to ground, then open load.
- R4: A condition is latched only after the same chosen code has been sampled on FILT_CYCLES consecutive clock edges. The write happens on the next edge. A shorter run, or a change to a different code, restarts the count.
- R5: A newly qualified code on a channel overwrites the code already stored for that channel.
- R6: On the edge where chip select (cs_n) is sampled high after having been low, all slots return to 2'b11, and this clear wins over a write in the same cycle. A condition that is still qualified is written again on the following edge.
- R7: On the edge where cs_n is first sampled low, diag_snap captures the stored codes. It then holds that value while cs_n stays low.
- R8: ok_snap[i] is 1 exactly when the snapshot code of channel i is 2'b11.
- R9: fault_drv_low is 1 one cycle after any stored code differs from 2'b11, and 0 one cycle after all stored codes are 2'b11.
- R10: While rst is high: every slot holds 2'b11, diag_snap is all ones, ok_snap is all ones, and fault_drv_low is 0.
- R11: A latched code stays stored after its raw condition goes away, until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, already synchronous to clk |
| ovld_raw | input | NCH | Raw overload / short-to-supply / overtemperature per channel |
| shgnd_raw | input | NCH | Raw short-to-ground per channel |
| open_raw | input | NCH | Raw open-load per channel |
| diag_snap | output | 2*NCH | Full-diagnosis byte captured at frame start |
| ok_snap | output | NCH | One-bit summary per channel, 1 = healthy |
| fault_drv_low | output | 1 | Drive enable for the open-drain fault pin, 1 = pull low |

## Verification
Results are due at fixed cycles:
- A code is stored on edge FILT_CYCLES+1, counted from the first edge that samples the condition.
- The fault flag follows one edge after the stored code changes.
- The snapshot and summary change on the edge that first samples cs_n low.
- The clear happens on the edge that first samples cs_n high.

The bench advances a cycle-level model of these rules by one edge at a time. It compares outputs 1 ns after each rising edge, so every comparison falls in the cycle where the result is due. Directed sequences cover these corner cases:
- a run one cycle too short
- a change of condition in the middle of a run
- priority between conditions
- an overwrite of a stored code
- a clear while a fault is still present

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;

  typedef enum logic [1:0] {
    DC_SHGND = 2'b00,
    DC_OPEN  = 2'b01,
    DC_OVLD  = 2'b10,
    DC_OK    = 2'b11
  } dcode_e;

  // Priority: overload, then short to ground, then open load.
  function automatic dcode_e pick_code(input logic ovl, input logic shg, input logic opn);
    if (ovl) return DC_OVLD;
    if (shg) return DC_SHGND;
    if (opn) return DC_OPEN;
    return DC_OK;
  endfunction

endpackage

// File: rtl/fdiag_cs_edge.sv
module fdiag_cs_edge (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  output logic rise,
  output logic fall
);
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b1;
    else     cs_q <= cs_n;
  end

  assign rise = cs_n & ~cs_q;
  assign fall = ~cs_n & cs_q;
endmodule

// File: rtl/fdiag_filter.sv
module fdiag_filter
  import fdiag_pkg::*;
#(
  parameter int unsigned HOLD = 22000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ovl,
  input  logic       shg,
  input  logic       opn,
  output logic       qual,
  output logic [1:0] qcode
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  dcode_e cand;
  dcode_e cand_q;
  logic [CW-1:0] run_q;

  always_comb cand = pick_code(ovl, shg, opn);

  // run_q counts consecutive samples of the same non-healthy code.
  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= DC_OK;
      run_q  <= '0;
    end else begin
      cand_q <= cand;
      if (cand == DC_OK)
        run_q <= '0;
      else if (cand != cand_q)
        run_q <= CW'(1);
      else if (run_q != HOLD_C)
        run_q <= run_q + CW'(1);
    end
  end

  assign qual  = (cand_q != DC_OK) && (run_q == HOLD_C);
  assign qcode = cand_q;
endmodule

// File: rtl/fdiag_slot.sv
module fdiag_slot
  import fdiag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       wr,
  input  logic [1:0] wcode,
  output logic [1:0] code
);
  always_ff @(posedge clk) begin
    if (rst)      code <= DC_OK;
    else if (clr) code <= DC_OK;
    else if (wr)  code <= wcode;
  end
endmodule

// File: rtl/fault_diag_reg.sv
module fault_diag_reg #(
  parameter int unsigned NCH         = 4,
  parameter int unsigned FILT_CYCLES = 22000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic [NCH-1:0]   ovld_raw,
  input  logic [NCH-1:0]   shgnd_raw,
  input  logic [NCH-1:0]   open_raw,
  output logic [2*NCH-1:0] diag_snap,
  output logic [NCH-1:0]   ok_snap,
  output logic             fault_drv_low
);
  localparam int unsigned BW = 2 * NCH;

  logic          cs_rise;
  logic          cs_fall;
  logic [NCH-1:0] qual;
  logic [BW-1:0]  qcodes;
  logic [BW-1:0]  live;
  logic [NCH-1:0] ok_now;

  fdiag_cs_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .rise (cs_rise),
    .fall (cs_fall)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      fdiag_filter #(.HOLD(FILT_CYCLES)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .ovl   (ovld_raw[g]),
        .shg   (shgnd_raw[g]),
        .opn   (open_raw[g]),
        .qual  (qual[g]),
        .qcode (qcodes[2*g +: 2])
      );

      fdiag_slot u_slot (
        .clk   (clk),
        .rst   (rst),
        .clr   (cs_rise),
        .wr    (qual[g]),
        .wcode (qcodes[2*g +: 2]),
        .code  (live[2*g +: 2])
      );

      assign ok_now[g] = &live[2*g +: 2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      diag_snap     <= '1;
      ok_snap       <= '1;
      fault_drv_low <= 1'b0;
    end else begin
      if (cs_fall) begin
        diag_snap <= live;
        ok_snap   <= ok_now;
      end
      fault_drv_low <= ~(&ok_now);
    end
  end
endmodule

// File: rtl/fault_diag_reg_chk.sv
module fault_diag_reg_chk #(
  parameter int unsigned NCH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic [2*NCH-1:0] live,
  input logic [NCH-1:0]   qual,
  input logic [2*NCH-1:0] diag_snap,
  input logic [NCH-1:0]   ok_snap,
  input logic             fault_drv_low
);
  function automatic logic [NCH-1:0] ok_of(input logic [2*NCH-1:0] b);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = &b[2*i +: 2];
    return r;
  endfunction

  assert_clear_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !$past(cs_n) && !$past(rst) && qual == '0) |=> (live == '1));

  assert_snap_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(cs_n) && !$past(rst)) |=> (diag_snap == $past(live)));

  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n) && !$past(rst)) |=> $stable(diag_snap));

  assert_summary_R8: assert property (@(posedge clk) disable iff (rst)
    ok_snap == ok_of(diag_snap));

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
    (live != '1) |=> fault_drv_low);

  assert_flag_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (live == '1) |=> !fault_drv_low);
endmodule

bind fault_diag_reg fault_diag_reg_chk #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cs_n          (cs_n),
  .live          (live),
  .qual          (qual),
  .diag_snap     (diag_snap),
  .ok_snap       (ok_snap),
  .fault_drv_low (fault_drv_low)
);

// File: tb/tb_fault_diag_reg.sv
`timescale 1ns/1ps
module tb_fault_diag_reg;
  localparam int NCH  = 4;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic [NCH-1:0] ovl = '0, shg = '0, opn = '0;
  logic [2*NCH-1:0] diag_snap;
  logic [NCH-1:0] ok_snap;
  logic fault_drv_low;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  logic [1:0] m_cq[NCH];
  int         m_cnt[NCH];
  logic [1:0] m_st[NCH];
  logic [7:0] m_snap;
  logic [3:0] m_ok;
  logic       m_oe;
  logic       m_csq;

  always #2.5 clk = ~clk;

  fault_diag_reg #(.NCH(NCH), .FILT_CYCLES(HOLD)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n),
    .ovld_raw(ovl), .shgnd_raw(shg), .open_raw(opn),
    .diag_snap(diag_snap), .ok_snap(ok_snap), .fault_drv_low(fault_drv_low)
  );

  function automatic logic [1:0] code_of(input logic o, input logic s, input logic p);
    if (o) return 2'b10;
    if (s) return 2'b00;
    if (p) return 2'b01;
    return 2'b11;
  endfunction

  function automatic logic [3:0] ok_of(input logic [7:0] b);
    logic [3:0] r;
    for (int i = 0; i < NCH; i++) r[i] = &b[2*i +: 2];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [1:0] n_cq[NCH];
    int         n_cnt[NCH];
    logic [1:0] n_st[NCH];
    logic [7:0] cur;
    logic [7:0] n_snap;
    logic [3:0] n_ok;
    logic n_oe, rise, fall, any;
    rise = cs_n & ~m_csq;
    fall = ~cs_n & m_csq;
    any = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      logic [1:0] c;
      logic q;
      c = code_of(ovl[i], shg[i], opn[i]);
      q = (m_cq[i] != 2'b11) && (m_cnt[i] == HOLD);
      n_cq[i] = c;
      if (c == 2'b11) n_cnt[i] = 0;
      else if (c != m_cq[i]) n_cnt[i] = 1;
      else n_cnt[i] = (m_cnt[i] < HOLD) ? m_cnt[i] + 1 : HOLD;
      n_st[i] = rise ? 2'b11 : (q ? m_cq[i] : m_st[i]);
      cur[2*i +: 2] = m_st[i];
      if (m_st[i] != 2'b11) any = 1'b1;
    end
    n_snap = fall ? cur : m_snap;
    n_ok   = fall ? ok_of(cur) : m_ok;
    n_oe   = any;
    @(posedge clk);
    #1;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        m_cq[i] = 2'b11; m_cnt[i] = 0; m_st[i] = 2'b11;
      end
      m_snap = 8'hFF; m_ok = 4'hF; m_oe = 1'b0; m_csq = 1'b1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        m_cq[i] = n_cq[i]; m_cnt[i] = n_cnt[i]; m_st[i] = n_st[i];
      end
      m_snap = n_snap; m_ok = n_ok; m_oe = n_oe; m_csq = cs_n;
      check("R7 snapshot", 32'(diag_snap), 32'(m_snap));
      check("R8 summary", 32'(ok_snap), 32'(m_ok));
      check("R9 fault flag", 32'(fault_drv_low), 32'(m_oe));
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  // one frame: capture at fall, clear at rise
  task automatic read_frame(output logic [7:0] b, output logic [3:0] ok);
    cs_n = 1'b0;
    tick();
    b = diag_snap;
    ok = ok_snap;
    cs_n = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] b;
    logic [3:0] ok;
    void'($urandom(32'd20240611));
    ticks(3);
    // R10 reset state
    check("R10 reset snapshot", 32'(diag_snap), 32'hFF);
    check("R10 reset summary", 32'(ok_snap), 32'hF);
    check("R10 reset flag", 32'(fault_drv_low), 32'h0);
    rst = 1'b0;
    ticks(2);

    // R4 run one short of HOLD does not latch
    ovl[0] = 1'b1; ticks(HOLD - 1); ovl[0] = 1'b0; ticks(3);
    read_frame(b, ok);
    check("R4 short run ignored", 32'(b), 32'hFF);

    // R1 R2 R11 open load on channel index 1 held exactly HOLD samples
    opn[1] = 1'b1; ticks(HOLD); opn[1] = 1'b0; ticks(3);
    check("R9 flag after latch", 32'(fault_drv_low), 32'h1);
    read_frame(b, ok);
    check("R1 R2 R11 open load code", 32'(b), 32'hF7);
    check("R8 summary for open load", 32'(ok), 32'hD);
    ticks(2);
    check("R6 R9 flag cleared", 32'(fault_drv_low), 32'h0);
    read_frame(b, ok);
    check("R6 cleared after rise", 32'(b), 32'hFF);

    // R3 priority
    ovl[2] = 1'b1; shg[2] = 1'b1; opn[2] = 1'b1; shg[3] = 1'b1; opn[3] = 1'b1;
    ticks(HOLD); ovl = '0; shg = '0; opn = '0; ticks(2);
    read_frame(b, ok);
    check("R3 R2 priority codes", 32'(b), 32'h2F);

    // R4 change of code restarts the count
    opn[0] = 1'b1; ticks(HOLD - 3); opn[0] = 1'b0; shg[0] = 1'b1; ticks(HOLD - 3);
    shg[0] = 1'b0; ticks(2);
    read_frame(b, ok);
    check("R4 restart on code change", 32'(b), 32'hFF);

    // R5 overwrite
    opn[0] = 1'b1; ticks(HOLD); opn[0] = 1'b0; ticks(2);
    shg[0] = 1'b1; ticks(HOLD); shg[0] = 1'b0; ticks(2);
    read_frame(b, ok);
    check("R5 overwrite to short ground", 32'(b), 32'hFC);

    // R6 clear while fault persists, then re-latch
    ovl[3] = 1'b1; ticks(HOLD + 4);
    read_frame(b, ok);
    check("R6 persistent first read", 32'(b), 32'hBF);
    ticks(2);
    read_frame(b, ok);
    check("R6 relatched after clear", 32'(b), 32'hBF);
    ovl[3] = 1'b0; ticks(2);
    read_frame(b, ok);
    check("R6 still stored before clear", 32'(b), 32'hBF);
    read_frame(b, ok);
    check("R6 clear with no fault", 32'(b), 32'hFF);

    // random phase: long runs of random raw levels and frames
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 9) == 0) begin
        for (int i = 0; i < NCH; i++) begin
          int r;
          r = $urandom_range(0, 7);
          ovl[i] = (r == 1);
          shg[i] = (r == 2) || (r == 5);
          opn[i] = (r == 3) || (r == 5) || (r == 6);
        end
      end
      if ($urandom_range(0, 24) == 0) cs_n = ~cs_n;
      tick();
    end
    finish_run();
  end
endmodule